// File: doc/BRIEF.md
# Single-Channel DMA Engine

This block is one DMA channel that copies data items from a source address range to a destination address range over a single-beat memory port. Software programs it through a small write-only configuration port: an initial source address, an initial destination address, an address-control word for each side, a control word, and an enable/trigger word. Enabling the channel copies the initial addresses and the transfer count into the current registers. The channel then works in atomic transfers of one item, or of a burst of four items. Each atomic transfer lowers the current count by one.

A service is started either by a software trigger or by one of several hardware request lines, and that line is answered on an acknowledge output. The channel supports single service (one atomic transfer per request) and whole service (one request runs until the count reaches zero), and demand or handshake request protocols. When the count reaches zero, the channel can raise a one-cycle completion interrupt. It then either reloads its current registers from the initial ones and stays armed, or switches itself off.

The memory side is a valid/ready port. The engine raises `mem_valid` with address, direction, size and write data. It holds all of them unchanged until a cycle in which `mem_ready` is high, and the beat completes on that clock edge. Read data must be valid on `mem_rdata` during the completing read beat. The memory may stall any beat for any number of cycles.

Top module: `dma_single_channel`

## Requirements
- R1: After reset, `mem_valid`, `dack`, `irq` and `chan_en` are low and `cur_count`, `cur_src` and `cur_dst` are zero.
- R2: Each item is moved by one read beat at `cur_src` followed by one write beat at `cur_dst`, and the write beat carries the data of that read. While `mem_valid` is high and `mem_ready` is low, address, direction and write data do not change. `mem_size` encodes 0 byte, 1 halfword, 2 word.
- R3: Configuration writes select a register with `cfg_sel`: 0 initial source, 1 source control (bit 0 set = fixed address), 2 initial destination, 3 destination control (bit 0 likewise), 4 control word, 5 enable/trigger (bit 1 enable, bit 0 software trigger). Writing the enable bit while the channel is off copies the initial source, destination and count (control bits 19:0) into the current registers.
- R4: Control bits 21:20 give the item size (00 byte, 01 halfword, 10 word). A side whose control bit 0 is clear steps its address by the item size after every beat. A fixed side keeps its address.
- R5: Control bit 28 set makes an atomic transfer move four items, and clear makes it move one item. The current count drops by exactly one per atomic transfer.
- R6: Control bit 27 clear (single service) performs one atomic transfer per request. Set (whole service), one request runs atomic transfers until the count is zero.
- R7: A whole service moves exactly item size x items per atomic x initial count bytes and writes no byte beyond that range.
- R8: With control bit 23 clear, a write to register 5 with bits 1 and 0 both set starts the channel. A trigger written while bit 1 is clear is discarded.
- R9: With control bit 23 set, only the request line numbered by control bits 26:24 starts the channel, and `dack` stays high for the whole service it started.
- R10: Control bit 31 clear (demand): a request still high after an atomic transfer starts the next one. Set (handshake): after an atomic transfer `dack` stays high until the request falls, then drops, and the next transfer needs a new request.
- R11: With control bit 29 set, `irq` pulses for exactly one cycle when the count reaches zero, and at no other time.
- R12: Control bit 22 clear: at zero, the current registers are reloaded from the initial ones (including values rewritten since the last load) and the channel stays enabled. Set: `chan_en` clears at zero and later requests move no data.
- R13: A start with item size 11, or with a current count of zero, is refused: no memory beat occurs, the count is unchanged and a pending software trigger is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| dreq | input | NREQ | Hardware request lines |
| dack | output | 1 | Acknowledge for the selected request line |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | AW | Byte address of the beat |
| mem_size | output | 2 | Item size of the beat |
| mem_wdata | output | 32 | Write data, low bytes significant |
| mem_rdata | input | 32 | Read data, low bytes significant |
| cur_src | output | AW | Current source address |
| cur_dst | output | AW | Current destination address |
| cur_count | output | CNT_W | Current transfer count |
| chan_en | output | 1 | Channel enable state |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The copy function is swept over every legal item size, both atomic widths and both source-address modes, with and without memory stalls. Byte-exact comparison of the destination separates stepping errors from size errors. A guard byte just past the range exposes overruns. A fixed source shows whether the read address moves. Software single-service triggers, a refused reserved size and a reload run separate the service modes and the reload path. Two hardware runs hold the request high, one in demand and one in handshake mode, and a wrong line is raised first. This tells the protocols apart and shows that request selection is exact.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  // configuration register select codes
  localparam logic [2:0] SEL_SRC_INIT = 3'd0;
  localparam logic [2:0] SEL_SRC_CTL  = 3'd1;
  localparam logic [2:0] SEL_DST_INIT = 3'd2;
  localparam logic [2:0] SEL_DST_CTL  = 3'd3;
  localparam logic [2:0] SEL_CTRL     = 3'd4;
  localparam logic [2:0] SEL_MASK     = 3'd5;

  localparam logic [1:0] SIZE_RSVD   = 2'b11;
  localparam int         BURST_ITEMS = 4;
  localparam int         BEAT_W      = $clog2(BURST_ITEMS);

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_READ,
    ENG_WRITE,
    ENG_FINISH
  } eng_state_t;

  // service options latched at the start of a service
  typedef struct packed {
    logic       handshake;
    logic       irq_en;
    logic       burst;
    logic       whole;
    logic       hw_src;
    logic       no_reload;
    logic [1:0] size;
  } svc_cfg_t;

  function automatic svc_cfg_t decode_ctrl(input logic [31:0] w);
    svc_cfg_t c;
    c.handshake = w[31];
    c.irq_en    = w[29];
    c.burst     = w[28];
    c.whole     = w[27];
    c.hw_src    = w[23];
    c.no_reload = w[22];
    c.size      = w[21:20];
    return c;
  endfunction

  function automatic logic [2:0] item_bytes(input logic [1:0] s);
    case (s)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_chan_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          take_trig,
  input  logic          finish_off,
  output logic [AW-1:0] src_init,
  output logic [AW-1:0] dst_init,
  output logic          src_fixed,
  output logic          dst_fixed,
  output logic [31:0]   ctrl_word,
  output logic          chan_en,
  output logic          trig_pend,
  output logic          load_cur
);

  logic mask_wr;

  assign mask_wr  = cfg_wr_en && (cfg_sel == SEL_MASK);
  // turning the channel on from off copies initial values into current ones
  assign load_cur = mask_wr && cfg_wdata[1] && !chan_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_init  <= '0;
      dst_init  <= '0;
      src_fixed <= 1'b0;
      dst_fixed <= 1'b0;
      ctrl_word <= '0;
    end else if (cfg_wr_en) begin
      case (cfg_sel)
        SEL_SRC_INIT: src_init  <= AW'(cfg_wdata);
        SEL_SRC_CTL:  src_fixed <= cfg_wdata[0];
        SEL_DST_INIT: dst_init  <= AW'(cfg_wdata);
        SEL_DST_CTL:  dst_fixed <= cfg_wdata[0];
        SEL_CTRL:     ctrl_word <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en   <= 1'b0;
      trig_pend <= 1'b0;
    end else begin
      if (mask_wr)         chan_en <= cfg_wdata[1];
      else if (finish_off) chan_en <= 1'b0;

      if (mask_wr)        trig_pend <= cfg_wdata[1] & cfg_wdata[0];
      else if (take_trig) trig_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_req_sel.sv
module dma_req_sel #(
  parameter int NREQ = 8
) (
  input  logic            hw_src,
  input  logic [2:0]      line,
  input  logic            trig_pend,
  input  logic [NREQ-1:0] dreq,
  output logic            line_lvl,
  output logic            want
);

  always_comb begin
    line_lvl = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      if (line == 3'(i)) line_lvl = dreq[i];
    end
    want = hw_src ? line_lvl : trig_pend;
  end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_chan_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  svc_cfg_t         cfg_now,
  input  logic [CNT_W-1:0] init_cnt,
  input  logic [AW-1:0]    src_init,
  input  logic [AW-1:0]    dst_init,
  input  logic             src_fixed,
  input  logic             dst_fixed,
  input  logic             chan_en,
  input  logic             want,
  input  logic             line_lvl,
  input  logic             load_cur,
  output logic             take_trig,
  output logic             finish_off,
  output logic             irq,
  output logic             dack,
  output logic             mem_valid,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [1:0]       mem_size,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ready,
  input  logic [31:0]      mem_rdata,
  output logic [AW-1:0]    cur_src,
  output logic [AW-1:0]    cur_dst,
  output logic [CNT_W-1:0] cur_cnt
);

  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BURST_ITEMS - 1);

  eng_state_t        state;
  svc_cfg_t          svc_q;
  logic [BEAT_W-1:0] beat;
  logic [31:0]       data_q;

  logic [AW-1:0]    step;
  logic [CNT_W-1:0] cnt_dec;
  logic             can_go, refuse, start, last_item, wr_hs, atom_end;

  always_comb begin
    step       = AW'(item_bytes(svc_q.size));
    can_go     = (state == ENG_IDLE) && chan_en && want;
    refuse     = can_go && ((cfg_now.size == SIZE_RSVD) || (cur_cnt == '0));
    start      = can_go && !refuse;
    take_trig  = (start || refuse) && !cfg_now.hw_src;
    last_item  = !svc_q.burst || (beat == BEAT_LAST);
    wr_hs      = (state == ENG_WRITE) && mem_ready;
    cnt_dec    = cur_cnt - CNT_W'(1);
    atom_end   = wr_hs && last_item;
    finish_off = atom_end && (cnt_dec == '0) && svc_q.no_reload;
  end

  assign mem_valid = (state == ENG_READ) || (state == ENG_WRITE);
  assign mem_we    = (state == ENG_WRITE);
  assign mem_addr  = (state == ENG_WRITE) ? cur_dst : cur_src;
  assign mem_size  = svc_q.size;
  assign mem_wdata = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      svc_q   <= '0;
      beat    <= '0;
      data_q  <= '0;
      cur_src <= '0;
      cur_dst <= '0;
      cur_cnt <= '0;
      irq     <= 1'b0;
      dack    <= 1'b0;
    end else begin
      irq <= 1'b0;
      unique case (state)
        ENG_IDLE: begin
          if (start) begin
            svc_q <= cfg_now;
            beat  <= '0;
            dack  <= cfg_now.hw_src;
            state <= ENG_READ;
          end
        end
        ENG_READ: begin
          if (mem_ready) begin
            data_q <= mem_rdata;
            if (!src_fixed) cur_src <= cur_src + step;
            state <= ENG_WRITE;
          end
        end
        ENG_WRITE: begin
          if (mem_ready) begin
            if (!dst_fixed) cur_dst <= cur_dst + step;
            if (!last_item) begin
              beat  <= beat + 1'b1;
              state <= ENG_READ;
            end else begin
              beat    <= '0;
              cur_cnt <= cnt_dec;
              if (cnt_dec == '0) begin
                irq   <= svc_q.irq_en;
                state <= ENG_FINISH;
                if (!svc_q.no_reload) begin
                  cur_src <= src_init;
                  cur_dst <= dst_init;
                  cur_cnt <= init_cnt;
                end
              end else if (svc_q.whole) begin
                state <= ENG_READ;
              end else begin
                state <= ENG_FINISH;
              end
            end
          end
        end
        ENG_FINISH: begin
          // handshake: keep acknowledging until the request line falls
          if (!(svc_q.hw_src && svc_q.handshake && line_lvl)) begin
            dack  <= 1'b0;
            state <= ENG_IDLE;
          end
        end
        default: state <= ENG_IDLE;
      endcase
      if (load_cur) begin
        cur_src <= src_init;
        cur_dst <= dst_init;
        cur_cnt <= init_cnt;
      end
    end
  end

endmodule

// File: rtl/dma_single_channel.sv
module dma_single_channel
  import dma_chan_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 20,
  parameter int NREQ  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [2:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic [NREQ-1:0]  dreq,
  output logic             dack,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [1:0]       mem_size,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic [AW-1:0]    cur_src,
  output logic [AW-1:0]    cur_dst,
  output logic [CNT_W-1:0] cur_count,
  output logic             chan_en,
  output logic             irq
);

  logic [AW-1:0]    src_init, dst_init;
  logic             src_fixed, dst_fixed;
  logic [31:0]      ctrl_word;
  logic             trig_pend, load_cur, take_trig, finish_off;
  logic             line_lvl, want;
  svc_cfg_t         cfg_now;
  logic [CNT_W-1:0] init_cnt;

  assign cfg_now  = decode_ctrl(ctrl_word);
  assign init_cnt = ctrl_word[CNT_W-1:0];

  dma_cfg_regs #(.AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .take_trig  (take_trig),
    .finish_off (finish_off),
    .src_init   (src_init),
    .dst_init   (dst_init),
    .src_fixed  (src_fixed),
    .dst_fixed  (dst_fixed),
    .ctrl_word  (ctrl_word),
    .chan_en    (chan_en),
    .trig_pend  (trig_pend),
    .load_cur   (load_cur)
  );

  dma_req_sel #(.NREQ(NREQ)) u_req (
    .hw_src    (cfg_now.hw_src),
    .line      (ctrl_word[26:24]),
    .trig_pend (trig_pend),
    .dreq      (dreq),
    .line_lvl  (line_lvl),
    .want      (want)
  );

  dma_engine #(.AW(AW), .CNT_W(CNT_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_now    (cfg_now),
    .init_cnt   (init_cnt),
    .src_init   (src_init),
    .dst_init   (dst_init),
    .src_fixed  (src_fixed),
    .dst_fixed  (dst_fixed),
    .chan_en    (chan_en),
    .want       (want),
    .line_lvl   (line_lvl),
    .load_cur   (load_cur),
    .take_trig  (take_trig),
    .finish_off (finish_off),
    .irq        (irq),
    .dack       (dack),
    .mem_valid  (mem_valid),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_size   (mem_size),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .cur_src    (cur_src),
    .cur_dst    (cur_dst),
    .cur_cnt    (cur_count)
  );

endmodule

// File: rtl/dma_single_channel_chk.sv
module dma_single_channel_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_size,
  input logic [31:0]   mem_wdata,
  input logic [31:0]   ctrl_word,
  input logic          line_lvl,
  input logic          dack,
  input logic          irq
);

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R2

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_size != 2'b11); // R13

  AST_RSVD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid && ctrl_word[21:20] == 2'b11 |=> !mem_valid); // R13

  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mem_valid && mem_ready && mem_we)); // R11

  AST_ACK_DURING_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && ctrl_word[23] |-> dack); // R9

  AST_HS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dack) && ctrl_word[31] && ctrl_word[23] |-> !$past(line_lvl)); // R10

endmodule

bind dma_single_channel dma_single_channel_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_size  (mem_size),
  .mem_wdata (mem_wdata),
  .ctrl_word (ctrl_word),
  .line_lvl  (line_lvl),
  .dack      (dack),
  .irq       (irq)
);

// File: tb/tb_dma_single_channel.sv
module tb_dma_single_channel;

  localparam int AW = 32;
  localparam int CW = 20;
  localparam int NR = 8;
  localparam int SRC = 'h10;
  localparam int DST = 'h80;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [NR-1:0] dreq = '0;
  logic          dack, mem_valid, mem_we, chan_en, irq;
  logic          mem_ready = 1'b0;
  logic [AW-1:0] mem_addr, cur_src, cur_dst;
  logic [1:0]    mem_size;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [CW-1:0] cur_count;

  logic [7:0] mem [0:255];
  int  wr_beats = 0, rd_beats = 0, irq_cnt = 0, valid_cyc = 0, cyc = 0;
  bit  stall_en = 1'b0;
  int  n_chk = 0, n_fail = 0;
  bit  reported = 1'b0;

  always #2 clk = ~clk;

  dma_single_channel #(.AW(AW), .CNT_W(CW), .NREQ(NR)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .dreq(dreq), .dack(dack), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_count(cur_count), .chan_en(chan_en), .irq(irq)
  );

  wire [7:0] ra = mem_addr[7:0];
  assign mem_rdata = {mem[8'(ra + 8'd3)], mem[8'(ra + 8'd2)], mem[8'(ra + 8'd1)], mem[ra]};

  // memory model: the beat completing at the next rising edge is recorded here
  always @(negedge clk) begin
    logic rdy;
    cyc++;
    rdy = stall_en ? ((cyc % 3) != 0) : 1'b1;
    if (mem_valid && rdy && rst_n) begin
      if (mem_we) begin
        for (int b = 0; b < (1 << mem_size); b++) mem[8'(ra + 8'(b))] = mem_wdata[8*b +: 8];
        wr_beats++;
      end else begin
        rd_beats++;
      end
    end
    mem_ready = rdy;
    if (irq) irq_cnt++;
    if (mem_valid) valid_cyc++;
  end

  function automatic logic [7:0] pat(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  function automatic logic [31:0] mk(input int cnt, input int dsz, input bit burst, input bit whole,
                                     input bit hw, input int line, input bit noreload,
                                     input bit irq_en, input bit hs);
    logic [19:0] c = cnt[19:0];
    logic [1:0]  d = dsz[1:0];
    logic [2:0]  l = line[2:0];
    return {hs, 1'b0, irq_en, burst, whole, l, hw, noreload, d, c};
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic cfg(input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = sel[2:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_off(input int lim);
    for (int i = 0; i < lim && chan_en; i++) @(negedge clk);
    idle(4);
  endtask

  task automatic init_mem();
    for (int i = 0; i < 256; i++) mem[i] = (i < 'h80) ? pat(i) : 8'hEE;
  endtask

  task automatic run_copy(input int dsz, input bit burst, input bit sfix, input bit stall);
    int sz, items, cnt, n, mism, bw, br, bi;
    sz = 1 << dsz; items = burst ? 4 : 1; cnt = 2 + dsz; n = cnt * items;
    init_mem(); stall_en = stall;
    bw = wr_beats; br = rd_beats; bi = irq_cnt;
    cfg(0, SRC); cfg(1, 32'(sfix)); cfg(2, DST); cfg(3, 0);
    cfg(4, mk(cnt, dsz, burst, 1'b1, 1'b0, 0, 1'b1, 1'b1, 1'b0));
    cfg(5, 32'h3);
    wait_off(3000);
    mism = 0;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < sz; b++)
        if (mem[DST + k*sz + b] != pat(SRC + (sfix ? 0 : k*sz) + b)) mism++;
    chk("R4 destination bytes mismatching", mism, 0);
    chk("R7 guard byte past range", mem[DST + n*sz], 8'hEE);
    chk("R5 write beats per service", wr_beats - bw, n);
    chk("R2 read beats equal write beats", rd_beats - br, wr_beats - bw);
    chk("R11 irq pulses per service", irq_cnt - bi, 1);
    chk("R5 count after whole service", cur_count, 0);
    chk("R12 enable cleared without reload", chan_en, 0);
    stall_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int bw, bi;
    init_mem();
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R1 mem_valid after reset", mem_valid, 0);
    chk("R1 dack after reset", dack, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 chan_en after reset", chan_en, 0);
    chk("R1 cur_count after reset", cur_count, 0);
    chk("R1 cur_src after reset", cur_src, 0);

    // sweep item size, atomic width, source mode, stalls
    for (int d = 0; d < 3; d++)
      for (int bu = 0; bu < 2; bu++)
        for (int sf = 0; sf < 2; sf++)
          run_copy(d, bit'(bu), bit'(sf), bit'((d + bu + sf) % 2));

    // single service by software trigger, trigger while off is ignored
    init_mem();
    cfg(0, SRC); cfg(1, 0); cfg(2, DST); cfg(3, 0);
    cfg(4, mk(3, 2, 1'b0, 1'b0, 1'b0, 0, 1'b1, 1'b1, 1'b0));
    bw = wr_beats; bi = irq_cnt;
    cfg(5, 32'h1);
    idle(20);
    chk("R8 trigger while off moves nothing", wr_beats - bw, 0);
    chk("R8 trigger while off leaves enable low", chan_en, 0);
    cfg(5, 32'h2);
    idle(20);
    chk("R3 count loaded on enable", cur_count, 3);
    chk("R3 source loaded on enable", cur_src, SRC);
    chk("R3 destination loaded on enable", cur_dst, DST);
    chk("R8 discarded trigger does not start", wr_beats - bw, 0);
    for (int t = 1; t <= 3; t++) begin
      cfg(5, 32'h3);
      idle(20);
      chk("R6 single service count step", cur_count, 3 - t);
      chk("R6 single service one atomic", wr_beats - bw, t);
      chk("R11 irq only at zero", irq_cnt - bi, (t == 3) ? 1 : 0);
    end
    chk("R4 word step on destination", cur_dst, DST + 12);
    chk("R12 enable cleared at zero", chan_en, 0);

    // reserved size refused
    bw = wr_beats;
    cfg(4, mk(5, 3, 1'b0, 1'b1, 1'b0, 0, 1'b1, 1'b0, 1'b0));
    valid_cyc = 0;
    cfg(5, 32'h3);
    idle(30);
    chk("R13 reserved size count unchanged", cur_count, 5);
    chk("R13 reserved size no beat", valid_cyc, 0);
    cfg(4, mk(5, 2, 1'b0, 1'b1, 1'b0, 0, 1'b1, 1'b0, 1'b0));
    idle(30);
    chk("R13 refused trigger discarded", wr_beats - bw, 0);
    cfg(5, 32'h3);
    wait_off(500);
    chk("R13 fresh trigger after fix runs", wr_beats - bw, 5);

    // auto reload
    init_mem();
    bw = wr_beats; bi = irq_cnt;
    cfg(0, SRC); cfg(2, DST);
    cfg(4, mk(2, 2, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b1, 1'b0));
    cfg(5, 32'h3);
    idle(100);
    chk("R12 reload keeps channel on", chan_en, 1);
    chk("R12 reload restores count", cur_count, 2);
    chk("R12 reload restores source", cur_src, SRC);
    chk("R11 irq with reload", irq_cnt - bi, 1);
    cfg(0, 'h20); cfg(2, 'h90);
    cfg(5, 32'h3);
    idle(100);
    chk("R12 second service beats", wr_beats - bw, 4);
    chk("R12 reload takes rewritten source", cur_src, 'h20);
    chk("R12 reload takes rewritten destination", cur_dst, 'h90);
    cfg(5, 32'h0);

    // hardware request, demand protocol
    init_mem();
    bw = wr_beats; bi = irq_cnt;
    cfg(0, SRC); cfg(2, DST);
    cfg(4, mk(4, 0, 1'b0, 1'b0, 1'b1, 2, 1'b1, 1'b1, 1'b0));
    cfg(5, 32'h2);
    dreq = 8'b0000_0010;
    idle(20);
    chk("R9 other line ignored", wr_beats - bw, 0);
    chk("R9 other line no ack", dack, 0);
    dreq = 8'b0000_0100;
    idle(3);
    chk("R9 ack raised for selected line", dack, 1);
    wait_off(500);
    chk("R10 demand runs while held", wr_beats - bw, 4);
    chk("R10 demand count", cur_count, 0);
    chk("R11 demand irq", irq_cnt - bi, 1);
    idle(20);
    chk("R12 request ignored after off", wr_beats - bw, 4);
    chk("R12 no ack after off", dack, 0);
    dreq = '0;

    // hardware request, handshake protocol
    bw = wr_beats;
    cfg(4, mk(3, 1, 1'b0, 1'b0, 1'b1, 2, 1'b1, 1'b0, 1'b1));
    cfg(5, 32'h2);
    idle(4);
    dreq = 8'b0000_0100;
    idle(30);
    chk("R10 handshake one atomic while held", wr_beats - bw, 1);
    chk("R10 handshake count while held", cur_count, 2);
    chk("R10 handshake ack held", dack, 1);
    dreq = '0;
    idle(5);
    chk("R10 handshake ack released", dack, 0);
    dreq = 8'b0000_0100;
    idle(30);
    chk("R10 handshake new request", cur_count, 1);
    chk("R4 halfword step", cur_dst, DST + 4);
    dreq = '0;
    idle(5);

    report();
  end

endmodule